// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block handles even-parity protection on the 32-bit multiplexed address/data bus of a PCI agent. Whenever the agent drives the bus (the address phase as initiator, or any data phase in which it supplies the data), it computes the parity bit over the 32 address/data lines and the 4 command/byte-enable lines. It presents that bit on the parity pin, with its output enable, one clock later.

When the agent receives data, it checks the parity bit returned by the other agent. Data is received by an initiator doing a read or a target accepting a write. A failed check drives the error line two clocks after the failing data phase and sets a sticky local-error flag. The error line has its own enable, which is raised only in the clock slot that belongs to a received data phase.

The agent also watches the sampled error line. A report arriving two clocks after a data phase that this agent supplied sets a sticky remote-error flag. Reports arriving at any other time are ignored. Each flag is cleared by its own write-one-to-clear strobe.

Top module: `pci_parity_unit`

## Requirements
- R1: In the clock after a driven phase, `par_o` equals the XOR of the 36 bits `ad_i` and `cbe_i` of that phase: 1 for an odd count of ones, 0 for an even count.
- R2: `par_oe_o` is high in the clock after a driven phase and low otherwise. A driven phase is one of two cases: `addr_ph_i`=1 with `role_init_i`=1, or `addr_ph_i`=0 and `data_ph_i`=1 with `role_init_i`==`dir_wr_i` (1 = initiator, 1 = write). `addr_ph_i` takes priority over `data_ph_i`.
- R3: A received data phase has `addr_ph_i`=0, `data_ph_i`=1 and `role_init_i`!=`dir_wr_i`. The `par_i` sampled one clock after such a phase is compared with the locally computed parity of that phase's `ad_i`/`cbe_i`.
- R4: `perr_oe_o` is high exactly in the clock two clocks after a received data phase. In that clock `perr_o` is 1 on a parity mismatch and 0 otherwise. `perr_o` is never 1 while `perr_oe_o` is 0.
- R5: A mismatch sets `loc_err_o`, visible in the same clock as the `perr_o` pulse, and it stays set.
- R6: `perr_i`=1 sampled two clocks after a data phase this agent drove sets `rem_err_o` from the next clock on.
- R7: `perr_i` sampled at any other time has no effect on `rem_err_o`.
- R8: `clr_loc_i`/`clr_rem_i` clear the matching flag at the next clock. A set arriving in the same clock wins over the clear.
- R9: While `rst` is high, `par_oe_o`, `perr_oe_o`, `perr_o`, `loc_err_o` and `rem_err_o` are 0, and no phase seen during reset produces a later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 32 | Address/data lines for the current phase |
| cbe_i | input | 4 | Command/byte-enable lines for the current phase |
| addr_ph_i | input | 1 | Current clock is an address phase |
| data_ph_i | input | 1 | Current clock is a data phase |
| role_init_i | input | 1 | 1 = agent is initiator, 0 = target |
| dir_wr_i | input | 1 | 1 = write transfer, 0 = read |
| par_i | input | 1 | Sampled parity line |
| perr_i | input | 1 | Sampled error line, active high |
| clr_loc_i | input | 1 | Write-one-to-clear for the local flag |
| clr_rem_i | input | 1 | Write-one-to-clear for the remote flag |
| par_o | output | 1 | Parity value to drive |
| par_oe_o | output | 1 | Parity output enable |
| perr_o | output | 1 | Error value to drive |
| perr_oe_o | output | 1 | Error output enable |
| loc_err_o | output | 1 | Sticky locally detected parity error |
| rem_err_o | output | 1 | Sticky remotely reported parity error |

## Verification
The hardest case to reach from the ports is a set that lands in the same clock as a clear. It needs a mismatching `par_i`, or an error report timed exactly two clocks after a sourced data phase, with the matching clear strobe raised in that same clock. Directed sequences build both alignments on purpose, and they also place error reports one clock early, one clock late and after received phases to show that those are ignored. A long run of mixed phases follows, with random roles, directions and occasional flipped parity, so that receive and source windows overlap back to back.

// File: rtl/pci_par_pkg.sv
`timescale 1ns/1ps
package pci_par_pkg;
    localparam int AD_W   = 32;
    localparam int CBE_W  = 4;
    localparam int WORD_W = AD_W + CBE_W;
    localparam int NFLAG  = 2;
    localparam int FLAG_LOC = 0;
    localparam int FLAG_REM = 1;

    typedef struct packed {
        logic [AD_W-1:0]  ad;
        logic [CBE_W-1:0] cbe;
    } bus_word_t;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_ADDR = 2'd1,
        PH_SRC  = 2'd2,
        PH_SNK  = 2'd3
    } phase_e;

    function automatic logic odd_ones(input bus_word_t w);
        return ^w;
    endfunction

    function automatic phase_e classify(input logic addr, input logic data,
                                        input logic init, input logic wr);
        if (addr)
            return init ? PH_ADDR : PH_NONE;
        else if (data)
            return (init == wr) ? PH_SRC : PH_SNK;
        else
            return PH_NONE;
    endfunction
endpackage

// File: rtl/pci_par_gen.sv
`timescale 1ns/1ps
module pci_par_gen
    import pci_par_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_word_t word,
    input  logic      drive,
    output logic      par_o,
    output logic      par_oe_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            par_o    <= 1'b0;
            par_oe_o <= 1'b0;
        end else begin
            par_o    <= odd_ones(word);
            par_oe_o <= drive;
        end
    end
endmodule

// File: rtl/pci_par_check.sv
`timescale 1ns/1ps
module pci_par_check
    import pci_par_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_word_t word,
    input  logic      sink,
    input  logic      par_i,
    output logic      err_hit,
    output logic      perr_o,
    output logic      perr_oe_o
);
    logic exp_par_q;
    logic rx_q;

    assign err_hit = rx_q && (par_i != exp_par_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_par_q <= 1'b0;
            rx_q      <= 1'b0;
            perr_o    <= 1'b0;
            perr_oe_o <= 1'b0;
        end else begin
            exp_par_q <= odd_ones(word);
            rx_q      <= sink;
            perr_o    <= err_hit;
            perr_oe_o <= rx_q;
        end
    end
endmodule

// File: rtl/pci_src_track.sv
`timescale 1ns/1ps
module pci_src_track #(
    parameter int LAG = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic perr_i,
    output logic rem_hit
);
    logic [LAG-1:0] src_pipe;

    generate
        if (LAG == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) src_pipe <= '0;
                else     src_pipe <= src;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) src_pipe <= '0;
                else     src_pipe <= {src_pipe[LAG-2:0], src};
            end
        end
    endgenerate

    assign rem_hit = perr_i && src_pipe[LAG-1];
endmodule

// File: rtl/pci_sticky.sv
`timescale 1ns/1ps
module pci_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= (q[i] && !clr[i]) || set[i];
        end
    end
endmodule

// File: rtl/pci_parity_unit.sv
`timescale 1ns/1ps
module pci_parity_unit
    import pci_par_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    input  logic             addr_ph_i,
    input  logic             data_ph_i,
    input  logic             role_init_i,
    input  logic             dir_wr_i,
    input  logic             par_i,
    input  logic             perr_i,
    input  logic             clr_loc_i,
    input  logic             clr_rem_i,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             perr_o,
    output logic             perr_oe_o,
    output logic             loc_err_o,
    output logic             rem_err_o
);
    bus_word_t        word;
    phase_e           ph;
    logic             loc_hit;
    logic             rem_hit;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] flags;

    assign word = '{ad: ad_i, cbe: cbe_i};
    assign ph   = classify(addr_ph_i, data_ph_i, role_init_i, dir_wr_i);

    pci_par_gen u_gen (
        .clk      (clk),
        .rst      (rst),
        .word     (word),
        .drive    (ph == PH_ADDR || ph == PH_SRC),
        .par_o    (par_o),
        .par_oe_o (par_oe_o)
    );

    pci_par_check u_chk (
        .clk       (clk),
        .rst       (rst),
        .word      (word),
        .sink      (ph == PH_SNK),
        .par_i     (par_i),
        .err_hit   (loc_hit),
        .perr_o    (perr_o),
        .perr_oe_o (perr_oe_o)
    );

    pci_src_track #(.LAG(2)) u_src (
        .clk     (clk),
        .rst     (rst),
        .src     (ph == PH_SRC),
        .perr_i  (perr_i),
        .rem_hit (rem_hit)
    );

    always_comb begin
        set_v           = '0;
        clr_v           = '0;
        set_v[FLAG_LOC] = loc_hit;
        set_v[FLAG_REM] = rem_hit;
        clr_v[FLAG_LOC] = clr_loc_i;
        clr_v[FLAG_REM] = clr_rem_i;
    end

    pci_sticky #(.N(NFLAG)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (set_v),
        .clr (clr_v),
        .q   (flags)
    );

    assign loc_err_o = flags[FLAG_LOC];
    assign rem_err_o = flags[FLAG_REM];
endmodule

// File: rtl/pci_parity_unit_chk.sv
`timescale 1ns/1ps
module pci_parity_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] ad_i,
    input logic [3:0]  cbe_i,
    input logic        addr_ph_i,
    input logic        data_ph_i,
    input logic        role_init_i,
    input logic        dir_wr_i,
    input logic        perr_i,
    input logic        clr_loc_i,
    input logic        clr_rem_i,
    input logic        par_o,
    input logic        par_oe_o,
    input logic        perr_o,
    input logic        perr_oe_o,
    input logic        loc_err_o,
    input logic        rem_err_o
);
    AST_PAR_VALUE: assert property (@(posedge clk) disable iff (rst)
        par_oe_o |-> (par_o == ^{$past(ad_i), $past(cbe_i)})); // R1
    AST_PERR_GATED: assert property (@(posedge clk) disable iff (rst)
        perr_o |-> perr_oe_o); // R4
    AST_PERR_SLOT: assert property (@(posedge clk) disable iff (rst)
        perr_oe_o |-> $past(data_ph_i && !addr_ph_i && (role_init_i != dir_wr_i), 2)); // R3
    AST_LOC_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(loc_err_o) |-> perr_o); // R5
    AST_REM_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(rem_err_o) |-> ($past(perr_i) &&
            $past(data_ph_i && !addr_ph_i && (role_init_i == dir_wr_i), 3))); // R7
    AST_LOC_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(loc_err_o) |-> $past(clr_loc_i)); // R8
    AST_REM_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(rem_err_o) |-> $past(clr_rem_i)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !(par_oe_o || perr_oe_o || perr_o || loc_err_o || rem_err_o)); // R9
endmodule

bind pci_parity_unit pci_parity_unit_chk u_parity_chk (
    .clk         (clk),
    .rst         (rst),
    .ad_i        (ad_i),
    .cbe_i       (cbe_i),
    .addr_ph_i   (addr_ph_i),
    .data_ph_i   (data_ph_i),
    .role_init_i (role_init_i),
    .dir_wr_i    (dir_wr_i),
    .perr_i      (perr_i),
    .clr_loc_i   (clr_loc_i),
    .clr_rem_i   (clr_rem_i),
    .par_o       (par_o),
    .par_oe_o    (par_oe_o),
    .perr_o      (perr_o),
    .perr_oe_o   (perr_oe_o),
    .loc_err_o   (loc_err_o),
    .rem_err_o   (rem_err_o)
);

// File: tb/pci_parity_unit_test.sv
`timescale 1ns/1ps
module pci_parity_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        addr_ph_i = 1'b0, data_ph_i = 1'b0;
    logic        role_init_i = 1'b0, dir_wr_i = 1'b0;
    logic        par_i = 1'b0, perr_i = 1'b0;
    logic        clr_loc_i = 1'b0, clr_rem_i = 1'b0;
    logic        par_o, par_oe_o, perr_o, perr_oe_o, loc_err_o, rem_err_o;

    always #5 clk = ~clk;

    pci_parity_unit uut (
        .clk(clk), .rst(rst), .ad_i(ad_i), .cbe_i(cbe_i),
        .addr_ph_i(addr_ph_i), .data_ph_i(data_ph_i),
        .role_init_i(role_init_i), .dir_wr_i(dir_wr_i),
        .par_i(par_i), .perr_i(perr_i),
        .clr_loc_i(clr_loc_i), .clr_rem_i(clr_rem_i),
        .par_o(par_o), .par_oe_o(par_oe_o), .perr_o(perr_o),
        .perr_oe_o(perr_oe_o), .loc_err_o(loc_err_o), .rem_err_o(rem_err_o)
    );

    typedef struct {
        bit        rst;
        bit [35:0] w;
        bit        addr, data, init, wr, par, perr, cl, cr;
    } smp_t;

    smp_t   hist[$];
    integer checks = 0;
    integer errors = 0;
    bit     loc_m = 0, rem_m = 0;
    bit     done = 0;
    bit [35:0] last_w = '0;

    function automatic bit f_drive(smp_t s);
        return !s.rst && ((s.addr && s.init) || (!s.addr && s.data && (s.init == s.wr)));
    endfunction
    function automatic bit f_sink(smp_t s);
        return !s.rst && !s.addr && s.data && (s.init != s.wr);
    endfunction
    function automatic bit f_src(smp_t s);
        return !s.rst && !s.addr && s.data && (s.init == s.wr);
    endfunction

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
        end
    endtask

    initial begin
        smp_t z;
        z = '{rst: 1, default: 0};
        for (int i = 0; i < 3; i++) hist.push_front(z);
    end

    always @(posedge clk) begin
        smp_t s;
        s.rst = rst; s.w = {ad_i, cbe_i};
        s.addr = addr_ph_i; s.data = data_ph_i; s.init = role_init_i; s.wr = dir_wr_i;
        s.par = par_i; s.perr = perr_i; s.cl = clr_loc_i; s.cr = clr_rem_i;
        hist.push_front(s);
        if (hist.size() > 4) void'(hist.pop_back());
    end

    // Reference model, evaluated once per cycle away from the active edge
    always @(negedge clk) begin
        if (!done && hist.size() >= 3) begin
            smp_t h0, h1, h2;
            bit exp_perr;
            h0 = hist[0]; h1 = hist[1]; h2 = hist[2];
            if (h0.rst) begin
                loc_m = 0; rem_m = 0;
                check("R9 par_oe", par_oe_o, 1'b0);
                check("R9 perr_oe", perr_oe_o, 1'b0);
                check("R9 perr", perr_o, 1'b0);
                check("R9 loc_err", loc_err_o, 1'b0);
                check("R9 rem_err", rem_err_o, 1'b0);
            end else begin
                exp_perr = f_sink(h1) && (h0.par != ^h1.w);
                loc_m = (loc_m && !h0.cl) || exp_perr;
                rem_m = (rem_m && !h0.cr) || (h0.perr && f_src(h2));
                check("R2 par_oe", par_oe_o, f_drive(h0));
                if (f_drive(h0)) check("R1 par", par_o, ^h0.w);
                check("R4 perr_oe", perr_oe_o, f_sink(h1));
                check("R3 perr", perr_o, exp_perr);
                check("R5/R8 loc_err", loc_err_o, loc_m);
                check("R6/R7/R8 rem_err", rem_err_o, rem_m);
            end
        end
    end

    // One bus clock of stimulus; par_i answers the previous phase (flip = bad parity)
    task automatic cyc(bit a, bit d, bit init, bit wr, bit [31:0] ad, bit [3:0] cbe,
                       bit flip, bit pe, bit cl, bit cr);
        addr_ph_i = a; data_ph_i = d; role_init_i = init; dir_wr_i = wr;
        ad_i = ad; cbe_i = cbe; par_i = (^last_w) ^ flip; perr_i = pe;
        clr_loc_i = cl; clr_rem_i = cr;
        last_w = {ad, cbe};
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: a phase held during reset must not leak out
        addr_ph_i = 1; role_init_i = 1; data_ph_i = 1;
        @(negedge clk);
        rst = 0;
        idle(3);
        // R1/R2: initiator write: address then data phases, odd and even words
        cyc(1, 0, 1, 1, 32'h0000_0001, 4'h7, 0, 0, 0, 0);
        cyc(0, 1, 1, 1, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, 0);
        cyc(0, 1, 1, 1, 32'h8000_0000, 4'h0, 0, 0, 0, 0);
        // R6: error report two clocks after the sourced phase above
        cyc(0, 0, 1, 1, 32'h0, 4'h0, 0, 1, 0, 0);
        idle(2);
        // R8: clear remote flag
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 0, 0, 1);
        idle(2);
        // R3/R4/R5: initiator read, good then bad parity
        cyc(1, 0, 1, 0, 32'h1234_5678, 4'h6, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 32'hA5A5_0F0F, 4'h3, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 32'h0000_0007, 4'h1, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 32'h0, 4'h0, 1, 0, 0, 0);
        idle(3);
        // R8: clear and a new mismatch in the same clock: set wins
        cyc(0, 1, 0, 1, 32'hDEAD_BEEF, 4'hC, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 1, 0, 1, 0);
        idle(2);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 0, 1, 0);
        idle(2);
        // R7: error reports one clock early, one late, and after received phases
        cyc(0, 1, 0, 0, 32'h0F0F_0F0F, 4'h5, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 1, 0, 0);
        cyc(0, 1, 1, 0, 32'h0000_00FF, 4'h2, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 1, 0, 0);
        cyc(1, 0, 0, 1, 32'h1111_1111, 4'h8, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 1, 0, 0);
        idle(2);
        // R6/R8: report on a target-read phase with simultaneous clear
        cyc(0, 1, 0, 0, 32'h2222_0000, 4'h9, 0, 0, 0, 0);
        idle(1);
        cyc(0, 0, 0, 0, 32'h0, 4'h0, 0, 1, 0, 1);
        idle(3);
        // Mixed traffic
        for (int i = 0; i < 2000; i++) begin
            bit [3:0] k;
            k = 4'($urandom);
            cyc(k[0] & k[1], k[2] | k[3], 1'($urandom), 1'($urandom), $urandom, 4'($urandom),
                ($urandom % 5) == 0, ($urandom % 4) == 0,
                ($urandom % 9) == 0, ($urandom % 9) == 0);
        end
        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule